// File: doc/BRIEF.md
# Slot-Ordered Supply Power Sequencer

This controller brings up to twelve supply channels up and down in a fixed order of time slots. Each channel is given a slot number. When both the hardware enable level and the software enable bit are high, the controller counts a start-up delay in slot 0. It then walks through slots 1 to 12. On entering a slot it switches on every channel enable given to that slot. It waits until the undervoltage comparators of those channels report good, then counts that slot's delay. After the last slot a reset hold-off runs, and then the active-low reset output is released.

Each slot's delay is a 4-bit code that maps to a whole number of ticks of a 25 µs timebase strobe. A fault timer limits how long any slot may wait for its supplies. A supply that sags after its slot has passed also aborts the bring-up. Channels marked as watch-only are ignored while the sequence runs. Once the sequence is done, any channel whose critical-fault enable is set shuts the block down when it drops below threshold. When the enable condition goes away, the block either turns everything off in one step or steps back down through the slots, spending each removed slot's delay before the next one.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, `ch_en_o` is all zero, `rst_n_o` is 0 and `fault_o` is 0.
- R2: Nothing starts unless `en_level_i` and `sw_en_i` are both 1. Slot 0 drives no channel enable and counts only its own delay.
- R3: Slot k's delay code sits at `slot_code_i[4k+3:4k]`. Delays count only cycles with `tick_i` high, in these tick counts: 0→1, 1→20, 2→40, 3→80, 4→120, 5→160, 6→240, 7→320, 8→400, 9→480, 10→1000, 11→4000, 12→8000, 13→16000, 14→32000, 15→64000. When a slot's monitors are already good, the next slot's enables follow one cycle of monitor check plus that slot's delay.
- R4: Channel i's slot number is `ch_slot_i[4i+3:4i]`. Slot number 0 means unassigned, and such a channel is never enabled. On entering slot k, every channel with slot number k enables in the same cycle.
- R5: The controller does not leave a slot until every non-watch-only channel of that slot has `uv_ok_i` high. A slot with no channels only waits its delay.
- R6: If a slot's monitors are not all good when `flt_limit_i` ticks have elapsed in that slot, `fault_o` goes to 1, all enables drop and reset stays asserted. `fault_o` holds until the enable condition is removed.
- R7: During bring-up, a non-watch-only channel of an already-passed slot going below threshold raises a fault, whatever `crit_en_i` holds.
- R8: Watch-only channels (`mon_only_i`) are never checked during bring-up. After bring-up, any assigned channel below threshold raises a fault only if its `crit_en_i` bit is set.
- R9: After the last slot's delay, `rst_n_o` rises once `rst_hold_i` more ticks have elapsed.
- R10: With `rev_mode_i`=0, removing the enable condition after bring-up clears every enable and asserts reset one cycle later.
- R11: With `rev_mode_i`=1 and bring-up complete, removing the enable condition asserts reset and removes slot 12's channels. Each removed slot's delay elapses before the next lower slot is removed, down to slot 1.
- R12: If the enable condition is lost before bring-up completes, all enables drop together on the next cycle, even in reverse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 25 µs timebase strobe, one cycle wide |
| en_level_i | input | 1 | Hardware enable level |
| sw_en_i | input | 1 | Software enable bit |
| rev_mode_i | input | 1 | 1 = step down in reverse slot order |
| flt_limit_i | input | 16 | Per-slot fault timeout in ticks (at least 1) |
| rst_hold_i | input | 16 | Reset hold-off in ticks (at least 1) |
| slot_code_i | input | 52 | Delay code for each slot 0..12, 4 bits each |
| ch_slot_i | input | 48 | Slot number for each channel, 4 bits each |
| mon_only_i | input | 12 | Per-channel watch-only flag |
| crit_en_i | input | 12 | Per-channel critical-fault enable |
| uv_ok_i | input | 12 | Per-channel above-undervoltage flag |
| ch_en_o | output | 12 | Per-channel supply enable |
| rst_n_o | output | 1 | Active-low system reset |
| fault_o | output | 1 | Sequencing or critical fault |

## Verification
The assertions assume that the slot map, delay codes, limits and watch-only and critical settings are held steady while a sequence runs. They also assume both limits are at least one tick. The bench only changes these settings while the controller is off or fully on. The supply model drives each `uv_ok_i` straight from its channel enable, with a mask that can hold chosen channels low. This means comparators only report good for switched-on channels, except where a test forces a sag on purpose. The tick strobe is held high every cycle, so tick counts and cycle counts match.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SLOT0,
    ST_UP_WAIT,
    ST_UP_DLY,
    ST_RST_WAIT,
    ST_ON,
    ST_DOWN,
    ST_FAULT
  } seq_state_e;

  localparam int TICK_W = 16;

  // Delay code to 25 us ticks.
  function automatic logic [TICK_W-1:0] code_to_ticks(input logic [3:0] code);
    logic [TICK_W-1:0] t;
    case (code)
      4'd0:    t = 16'd1;
      4'd1:    t = 16'd20;
      4'd2:    t = 16'd40;
      4'd3:    t = 16'd80;
      4'd4:    t = 16'd120;
      4'd5:    t = 16'd160;
      4'd6:    t = 16'd240;
      4'd7:    t = 16'd320;
      4'd8:    t = 16'd400;
      4'd9:    t = 16'd480;
      4'd10:   t = 16'd1000;
      4'd11:   t = 16'd4000;
      4'd12:   t = 16'd8000;
      4'd13:   t = 16'd16000;
      4'd14:   t = 16'd32000;
      default: t = 16'd64000;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/pwr_seq_timer.sv
`timescale 1ns/1ps
module pwr_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (clr)                     cnt_q <= '0;
    else if (tick && (cnt_q != '1))   cnt_q <= cnt_q + CNT_W'(1);
  end

  // Fires on the tick that completes `limit` ticks since the last clear.
  assign expire = tick && (cnt_q == (limit - CNT_W'(1)));

endmodule

// File: rtl/pwr_seq_chan_map.sv
`timescale 1ns/1ps
module pwr_seq_chan_map #(
  parameter int NUM_CH = 12,
  parameter int SLOT_W = 4
) (
  input  logic [NUM_CH*SLOT_W-1:0] ch_slot,
  input  logic [NUM_CH-1:0]        mon_only,
  input  logic [NUM_CH-1:0]        crit_en,
  input  logic [NUM_CH-1:0]        uv_ok,
  input  logic [SLOT_W-1:0]        lvl,
  input  logic [SLOT_W-1:0]        cur,
  input  logic                     cur_passed,
  input  logic                     done_phase,
  output logic [NUM_CH-1:0]        ch_en,
  output logic                     slot_ok,
  output logic                     seq_flt,
  output logic                     crit_flt
);

  logic [NUM_CH-1:0] assigned_v;
  logic [NUM_CH-1:0] wait_v;
  logic [NUM_CH-1:0] passed_v;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [SLOT_W-1:0] s;
    assign s             = ch_slot[i*SLOT_W +: SLOT_W];
    assign assigned_v[i] = (s != '0);
    assign ch_en[i]      = assigned_v[i] && (s <= lvl);
    assign wait_v[i]     = assigned_v[i] && !mon_only[i] && (s == cur);
    assign passed_v[i]   = assigned_v[i] && !mon_only[i] &&
                           ((s < cur) || (cur_passed && (s == cur)));
  end

  assign slot_ok  = &(~wait_v | uv_ok);
  assign seq_flt  = |(passed_v & ~uv_ok);
  assign crit_flt = done_phase && |(assigned_v & crit_en & ~uv_ok);

endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NUM_CH    = 12,
  parameter int NUM_SLOTS = 13,
  parameter int CNT_W     = 16,
  parameter int CODE_W    = 4,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_i,
  input  logic                      en_level_i,
  input  logic                      sw_en_i,
  input  logic                      rev_mode_i,
  input  logic [CNT_W-1:0]          flt_limit_i,
  input  logic [CNT_W-1:0]          rst_hold_i,
  input  logic [NUM_SLOTS*CODE_W-1:0] slot_code_i,
  input  logic [NUM_CH*SLOT_W-1:0]  ch_slot_i,
  input  logic [NUM_CH-1:0]         mon_only_i,
  input  logic [NUM_CH-1:0]         crit_en_i,
  input  logic [NUM_CH-1:0]         uv_ok_i,
  output logic [NUM_CH-1:0]         ch_en_o,
  output logic                      rst_n_o,
  output logic                      fault_o
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [SLOT_W-1:0] ONE  = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] TWO  = SLOT_W'(2);

  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] cur_q, cur_d;
  logic [SLOT_W-1:0] lvl_q, lvl_d;
  logic              fault_q, fault_d;

  // Named events, also used by the checker.
  logic run_req;
  logic ev_timeout, ev_seq_flt, ev_crit, ev_fault;
  logic restart;

  logic slot_ok, seq_flt, crit_flt;
  logic dly_expire, ft_expire;
  logic [CODE_W-1:0] cur_code;
  logic [CNT_W-1:0]  dly_limit;
  logic in_up, done_phase;

  assign run_req    = en_level_i && sw_en_i;
  assign in_up      = (state_q == ST_UP_WAIT) || (state_q == ST_UP_DLY);
  assign done_phase = (state_q == ST_RST_WAIT) || (state_q == ST_ON);
  assign cur_code   = slot_code_i[cur_q*CODE_W +: CODE_W];
  assign dly_limit  = (state_q == ST_RST_WAIT) ? rst_hold_i
                                               : CNT_W'(code_to_ticks(cur_code));

  pwr_seq_chan_map #(
    .NUM_CH (NUM_CH),
    .SLOT_W (SLOT_W)
  ) u_map (
    .ch_slot    (ch_slot_i),
    .mon_only   (mon_only_i),
    .crit_en    (crit_en_i),
    .uv_ok      (uv_ok_i),
    .lvl        (lvl_q),
    .cur        (cur_q),
    .cur_passed (state_q == ST_UP_DLY),
    .done_phase (done_phase),
    .ch_en      (ch_en_o),
    .slot_ok    (slot_ok),
    .seq_flt    (seq_flt),
    .crit_flt   (crit_flt)
  );

  pwr_seq_timer #(.CNT_W(CNT_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (restart),
    .tick   (tick_i),
    .limit  (dly_limit),
    .expire (dly_expire)
  );

  pwr_seq_timer #(.CNT_W(CNT_W)) u_flt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (restart),
    .tick   (tick_i),
    .limit  (flt_limit_i),
    .expire (ft_expire)
  );

  assign ev_timeout = (state_q == ST_UP_WAIT) && ft_expire && !slot_ok;
  assign ev_seq_flt = in_up && seq_flt;
  assign ev_crit    = crit_flt;
  assign ev_fault   = ev_timeout || ev_seq_flt || ev_crit;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    lvl_d   = lvl_q;
    fault_d = fault_q;
    case (state_q)
      ST_OFF: begin
        if (run_req) begin
          state_d = ST_SLOT0;
          cur_d   = '0;
        end
      end
      ST_SLOT0: begin
        if (!run_req) begin
          state_d = ST_OFF;
        end else if (dly_expire) begin
          state_d = ST_UP_WAIT;
          cur_d   = ONE;
          lvl_d   = ONE;
        end
      end
      ST_UP_WAIT, ST_UP_DLY: begin
        if (ev_fault) begin
          state_d = ST_FAULT;
          lvl_d   = '0;
          fault_d = 1'b1;
        end else if (!run_req) begin
          state_d = ST_OFF;
          lvl_d   = '0;
        end else if (state_q == ST_UP_WAIT) begin
          if (slot_ok) state_d = ST_UP_DLY;
        end else if (dly_expire) begin
          if (cur_q == LAST) begin
            state_d = ST_RST_WAIT;
          end else begin
            state_d = ST_UP_WAIT;
            cur_d   = cur_q + ONE;
            lvl_d   = cur_q + ONE;
          end
        end
      end
      ST_RST_WAIT, ST_ON: begin
        if (ev_fault) begin
          state_d = ST_FAULT;
          lvl_d   = '0;
          fault_d = 1'b1;
        end else if (!run_req) begin
          if (rev_mode_i) begin
            state_d = ST_DOWN;
            cur_d   = LAST;
            lvl_d   = LAST - ONE;
          end else begin
            state_d = ST_OFF;
            lvl_d   = '0;
          end
        end else if ((state_q == ST_RST_WAIT) && dly_expire) begin
          state_d = ST_ON;
        end
      end
      ST_DOWN: begin
        if (dly_expire) begin
          if (cur_q <= TWO) begin
            state_d = ST_OFF;
            cur_d   = '0;
            lvl_d   = '0;
          end else begin
            cur_d = cur_q - ONE;
            lvl_d = cur_q - TWO;
          end
        end
      end
      ST_FAULT: begin
        if (!run_req) begin
          state_d = ST_OFF;
          fault_d = 1'b0;
        end
      end
      default: begin
        state_d = ST_OFF;
        lvl_d   = '0;
      end
    endcase
  end

  assign restart = (state_d != state_q) || (cur_d != cur_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cur_q   <= '0;
      lvl_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      lvl_q   <= lvl_d;
      fault_q <= fault_d;
    end
  end

  assign rst_n_o = (state_q == ST_ON);
  assign fault_o = fault_q;

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_chk #(
  parameter int NUM_CH = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_req,
  input logic              rev_mode,
  input logic [NUM_CH-1:0] ch_en,
  input logic              rst_ok,
  input logic              fault,
  input logic              ev_fault
);

  assert_fault_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (ch_en == '0) && !rst_ok);

  assert_fault_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> fault);

  assert_drop_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && !run_req) |=> !rst_ok);

  assert_flat_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && !run_req && !rev_mode) |=> (ch_en == '0));

  assert_grow_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_en & ~$past(ch_en)) != '0) |-> $past(run_req));

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_req  (run_req),
  .rev_mode (rev_mode_i),
  .ch_en    (ch_en_o),
  .rst_ok   (rst_n_o),
  .fault    (fault_o),
  .ev_fault (ev_fault)
);

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb;

  localparam int NCH = 12;
  localparam int NSL = 13;
  localparam int SW  = 4;
  localparam int CW  = 16;
  localparam int FLT = 50;
  localparam int RHD = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n, tick_i, en_level_i, sw_en_i, rev_mode_i;
  logic [CW-1:0]   flt_limit_i, rst_hold_i;
  logic [NSL*4-1:0] slot_code_i;
  logic [NCH*SW-1:0] ch_slot_i;
  logic [NCH-1:0]  mon_only_i, crit_en_i, uv_ok_i, ch_en_o, hold_low;
  logic            rst_n_o, fault_o;

  assign uv_ok_i = ch_en_o & ~hold_low;

  pwr_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_level_i(en_level_i),
    .sw_en_i(sw_en_i), .rev_mode_i(rev_mode_i), .flt_limit_i(flt_limit_i),
    .rst_hold_i(rst_hold_i), .slot_code_i(slot_code_i), .ch_slot_i(ch_slot_i),
    .mon_only_i(mon_only_i), .crit_en_i(crit_en_i), .uv_ok_i(uv_ok_i),
    .ch_en_o(ch_en_o), .rst_n_o(rst_n_o), .fault_o(fault_o)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ticks_of(input int code);
    int tbl[16] = '{1, 20, 40, 80, 120, 160, 240, 320,
                    400, 480, 1000, 4000, 8000, 16000, 32000, 64000};
    return tbl[code];
  endfunction

  function automatic logic [13:0] snap(input logic [11:0] m, input logic r, input logic f);
    return {f, r, m};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Scoreboard
  logic [13:0] exp_q[$];
  string       tag_q[$];
  logic [13:0] prev_snap = '0;
  int t_set[NCH];
  int t_clr[NCH];
  int t_rst, t_flt;

  task automatic push(input logic [13:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic push_lvls(input int lo, input int hi, input string t);
    for (int k = lo; k <= hi; k++) push(snap(12'((1 << k) - 1), 1'b0, 1'b0), t);
  endtask

  task automatic push_up(input string t);
    push_lvls(1, 10, t);
    push(snap(12'hFFF, 1'b0, 1'b0), t);
    push(snap(12'hFFF, 1'b1, 1'b0), t);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [13:0] now, e;
      string t;
      now = {fault_o, rst_n_o, ch_en_o};
      if (now !== prev_snap) begin
        for (int b = 0; b < NCH; b++) begin
          if (now[b] && !prev_snap[b]) t_set[b] = cyc;
          if (!now[b] && prev_snap[b]) t_clr[b] = cyc;
        end
        if (now[12] && !prev_snap[12]) t_rst = cyc;
        if (now[13] && !prev_snap[13]) t_flt = cyc;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL unexpected output change: actual %h expected none", now);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (now !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, now, e);
          end
        end
        prev_snap = now;
      end
    end
  end

  task automatic drain(input string t);
    int n = 0;
    while (exp_q.size() != 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0, t, exp_q.size(), 0);
  endtask

  task automatic wait_bit(input int b);
    int n = 0;
    while (!ch_en_o[b] && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; tick_i = 1; en_level_i = 0; sw_en_i = 0; rev_mode_i = 0;
    flt_limit_i = CW'(FLT); rst_hold_i = CW'(RHD);
    mon_only_i = '0; crit_en_i = '0; hold_low = '0;
    slot_code_i = '0;
    slot_code_i[3*4 +: 4] = 4'd1;
    slot_code_i[5*4 +: 4] = 4'd1;
    for (int i = 0; i < NCH; i++) ch_slot_i[i*SW +: SW] = SW'((i < 11) ? i + 1 : 11);
    repeat (5) @(negedge clk);
    chk({fault_o, rst_n_o, ch_en_o} == '0, "R1 reset", {fault_o, rst_n_o, ch_en_o}, 0);
    rst_n = 1;

    // R2: one enable alone never starts
    en_level_i = 1;
    repeat (30) @(negedge clk);
    chk(ch_en_o == '0 && !rst_n_o, "R2 level only", ch_en_o, 0);
    en_level_i = 0; sw_en_i = 1;
    repeat (30) @(negedge clk);
    chk(ch_en_o == '0 && !rst_n_o, "R2 software only", ch_en_o, 0);

    // R4/R5 bring-up with slot 4 supply late
    hold_low = 12'h008;
    push_up("R4 bring-up order");
    en_level_i = 1;
    wait_bit(3);
    repeat (30) @(negedge clk);
    chk(ch_en_o[4] == 1'b0, "R5 slot held by low supply", ch_en_o[4], 0);
    hold_low = '0;
    drain("R5 bring-up complete");
    chk(t_set[3] - t_set[2] == ticks_of(1) + 1, "R3 slot delay", t_set[3] - t_set[2], ticks_of(1) + 1);
    chk(t_set[10] == t_set[11], "R4 same slot together", t_set[11], t_set[10]);
    chk(t_rst - t_set[11] == (ticks_of(0) + 1) * 2 + RHD, "R9 reset hold-off",
        t_rst - t_set[11], (ticks_of(0) + 1) * 2 + RHD);

    // R10 simultaneous power-down
    push(snap(12'h000, 1'b0, 1'b0), "R10 all off");
    sw_en_i = 0;
    drain("R10 drain");
    chk(t_clr[0] == t_clr[11], "R10 same cycle", t_clr[0], t_clr[11]);

    // R11 reverse power-down
    rev_mode_i = 1;
    push_up("R11 bring-up");
    sw_en_i = 1;
    drain("R11 up drain");
    push(snap(12'hFFF, 1'b0, 1'b0), "R11 reset first");
    for (int l = 10; l >= 0; l--) push(snap(12'((1 << l) - 1), 1'b0, 1'b0), "R11 reverse step");
    sw_en_i = 0;
    drain("R11 down drain");
    chk(t_clr[3] - t_clr[4] == ticks_of(1), "R11 removed slot delay", t_clr[3] - t_clr[4], ticks_of(1));
    chk(t_clr[11] < t_clr[0], "R11 top slot first", t_clr[11], t_clr[0]);

    // R12 loss mid bring-up in reverse mode
    push_lvls(1, 4, "R12 partial");
    push(snap(12'h000, 1'b0, 1'b0), "R12 flat off");
    sw_en_i = 1;
    wait_bit(3);
    sw_en_i = 0;
    drain("R12 drain");
    rev_mode_i = 0;

    // R6 fault timeout
    hold_low = 12'h040;
    push_lvls(1, 7, "R6 partial");
    push(snap(12'h000, 1'b0, 1'b1), "R6 timeout fault");
    sw_en_i = 1;
    drain("R6 drain");
    chk(t_flt - t_set[6] == FLT, "R6 timeout length", t_flt - t_set[6], FLT);
    repeat (10) @(negedge clk);
    chk(fault_o == 1'b1 && ch_en_o == '0, "R6 fault holds", fault_o, 1);
    push(snap(12'h000, 1'b0, 1'b0), "R6 fault clears");
    sw_en_i = 0;
    drain("R6 clear drain");
    hold_low = '0;

    // R7 passed slot sags
    push_lvls(1, 6, "R7 partial");
    push(snap(12'h000, 1'b0, 1'b1), "R7 sag fault");
    sw_en_i = 1;
    wait_bit(5);
    hold_low = 12'h002;
    drain("R7 drain");
    hold_low = '0;
    push(snap(12'h000, 1'b0, 1'b0), "R7 clear");
    sw_en_i = 0;
    drain("R7 clear drain");

    // R8 watch-only channel
    mon_only_i = 12'h100;
    hold_low = 12'h100;
    push_up("R8 bring-up ignores watch-only");
    sw_en_i = 1;
    drain("R8 up drain");
    repeat (20) @(negedge clk);
    chk(rst_n_o == 1'b1 && fault_o == 1'b0, "R8 no fault without critical", rst_n_o, 1);
    push(snap(12'h000, 1'b0, 1'b1), "R8 critical fault");
    crit_en_i = 12'h100;
    drain("R8 crit drain");
    push(snap(12'h000, 1'b0, 1'b0), "R8 clear");
    sw_en_i = 0;
    drain("R8 clear drain");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard empty", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule